// File: doc/BRIEF.md
# Half-Precision Multiply-Accumulate into Single Precision

This block is a sequential multiply-accumulate engine. Each valid cycle it takes two 16-bit operands, multiplies them, and adds the product into a 32-bit single-precision accumulator. A select input chooses how the operands are read: either as IEEE half precision or as the 16-bit brain-float layout. Both layouts share the sign bit and the exponent and fraction order of single precision.

The product of two 16-bit significands always fits in the 24-bit single-precision significand, so the multiply is exact. The only rounding in a step happens when that product is added to the accumulator, and it is round-to-nearest-even. Exactly two terms meet per rounding. A product that falls below half an accumulator ulp is therefore lost, even if many such products would add up to something visible. Subnormal operands count as zero. A sum whose rounded magnitude lands below the smallest normal single-precision value is flushed to zero.

The engine is used by clearing the accumulator once, streaming operand pairs with a valid strobe, and reading the running sum. The sum is confirmed by an output strobe one cycle after each accepted pair.

Top module: `half_mac_fp32`

## Requirements
- R1: With `fmt_bf16`=0 an operand is sign[15], exponent[14:10] (bias 15), fraction[9:0]. With `fmt_bf16`=1 it is sign[15], exponent[14:7] (bias 127), fraction[6:0]. An all-ones exponent means infinity (fraction 0) or NaN (fraction non-zero).
- R2: An operand whose exponent field is 0 is treated as a zero of its sign, whatever its fraction.
- R3: On every accepted step the accumulator becomes the round-to-nearest-even single-precision value of (accumulator + a×b), with one rounding per step and an exact product.
- R4: A finite non-zero sum whose rounded magnitude is below 2^-126 is written as a zero carrying the sign of the sum.
- R5: A finite sum whose rounded exponent exceeds 127 becomes infinity of the sum's sign (0x7F800000 or 0xFF800000).
- R6: A NaN operand, a NaN accumulator, infinity times zero, or adding infinities of opposite sign gives 0x7FC00000.
- R7: Otherwise an infinite product or an infinite accumulator gives infinity with that term's sign.
- R8: An exact cancellation of non-zero terms gives +0. A zero plus a zero keeps their sign when the signs agree and gives +0 when they differ.
- R9: `clr` loads +0 into the accumulator on the next edge and takes priority over `in_valid`. That step is dropped and `out_valid` is 0 after it.
- R10: The accumulator changes only on an edge where `in_valid` is 1 and `clr` is 0. `out_valid` is 1 exactly in the cycle after such an edge.
- R11: After reset the accumulator is +0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Load +0 into the accumulator |
| in_valid | input | 1 | Operand pair present this cycle |
| fmt_bf16 | input | 1 | 0: half precision operands, 1: brain-float operands |
| op_a | input | 16 | First multiplicand |
| op_b | input | 16 | Second multiplicand |
| acc_out | output | 32 | Accumulator, single precision |
| out_valid | output | 1 | Accumulator reflects a step accepted on the previous edge |

## Verification
The block has no parameters, so the bench elaborates the single fixed configuration. It works both operand layouts against a bit-exact model kept in the bench, which uses exact wide-integer arithmetic. The wide exponent range of the brain-float layout makes products above 2^127 and below 2^-126 reachable, so overflow and result flushing can be driven directly. Half-precision operands with exponents near 2^-12 place products at exactly half and below half an accumulator ulp, which exercises ties-to-even and lost contributions.

// File: rtl/half_mac_fp32.sv
module half_mac_fp32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        in_valid,
  input  logic        fmt_bf16,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  output logic [31:0] acc_out,
  output logic        out_valid
);

  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  typedef struct packed {
    logic               sgn;
    logic               zero;
    logic               inf;
    logic               nan;
    logic signed [12:0] exp;
    logic [10:0]        sig;
  } half_t;

  function automatic half_t unpack_half(input logic [15:0] x, input logic bf);
    half_t      h;
    logic [7:0] e;
    logic [9:0] f;
    logic       top;
    if (bf) begin
      e = x[14:7];
      f = {x[6:0], 3'b000};
    end else begin
      e = {3'b000, x[14:10]};
      f = x[9:0];
    end
    top    = bf ? (e == 8'hFF) : (e == 8'h1F);
    h.sgn  = x[15];
    h.zero = (e == 8'd0);
    h.inf  = top && (f == 10'd0);
    h.nan  = top && (f != 10'd0);
    h.exp  = $signed({5'd0, e}) - (bf ? 13'sd127 : 13'sd15);
    h.sig  = {1'b1, f};
    return h;
  endfunction

  half_t ha, hb;
  assign ha = unpack_half(op_a, fmt_bf16);
  assign hb = unpack_half(op_b, fmt_bf16);

  logic [21:0]        prod;
  logic               p_sgn, p_zero, p_inf;
  logic signed [12:0] p_exp;
  logic [23:0]        p_sig;

  assign prod   = {11'd0, ha.sig} * {11'd0, hb.sig};
  assign p_sgn  = ha.sgn ^ hb.sgn;
  assign p_zero = ha.zero | hb.zero;
  assign p_inf  = ha.inf | hb.inf;
  assign p_exp  = ha.exp + hb.exp + (prod[21] ? 13'sd1 : 13'sd0);
  assign p_sig  = prod[21] ? {prod, 2'b00} : {prod[20:0], 3'b000};

  logic               a_sgn, a_zero, a_inf, a_nan;
  logic signed [12:0] a_exp;
  logic [23:0]        a_sig;

  assign a_sgn  = acc_out[31];
  assign a_zero = (acc_out[30:23] == 8'd0);
  assign a_inf  = (acc_out[30:23] == 8'hFF) && (acc_out[22:0] == 23'd0);
  assign a_nan  = (acc_out[30:23] == 8'hFF) && (acc_out[22:0] != 23'd0);
  assign a_exp  = a_zero ? -13'sd1024 : $signed({5'd0, acc_out[30:23]}) - 13'sd127;
  assign a_sig  = a_zero ? 24'd0 : {1'b1, acc_out[22:0]};

  logic               acc_big, big_sgn;
  logic signed [12:0] big_exp, sml_exp, diff, n_exp, r_exp;
  logic [23:0]        big_sig, sml_sig;
  logic [4:0]         shamt, lead, lsh;
  logic [53:0]        wide;
  logic [26:0]        sml_ext, norm;
  logic [27:0]        sum;
  logic               rnd_up;
  logic [24:0]        rsig;
  logic [22:0]        r_frac;
  logic [31:0]        gen, nxt;

  always_comb begin
    acc_big = (a_exp > p_exp) || ((a_exp == p_exp) && (a_sig >= p_sig));
    big_exp = acc_big ? a_exp : p_exp;
    big_sig = acc_big ? a_sig : p_sig;
    big_sgn = acc_big ? a_sgn : p_sgn;
    sml_exp = acc_big ? p_exp : a_exp;
    sml_sig = acc_big ? p_sig : a_sig;
    diff    = big_exp - sml_exp;
    shamt   = (diff > 13'sd27) ? 5'd27 : diff[4:0];
    wide    = {sml_sig, 3'b000, 27'd0} >> shamt;
    sml_ext = {wide[53:28], wide[27] | (|wide[26:0])};
    if (a_sgn ^ p_sgn) sum = {1'b0, big_sig, 3'b000} - {1'b0, sml_ext};
    else               sum = {1'b0, big_sig, 3'b000} + {1'b0, sml_ext};

    lead = 5'd0;
    for (int i = 0; i < 27; i++) if (sum[i]) lead = i[4:0];
    lsh = 5'd26 - lead;
    if (sum[27]) begin
      norm  = {sum[27:2], sum[1] | sum[0]};
      n_exp = big_exp + 13'sd1;
    end else begin
      norm  = sum[26:0] << lsh;
      n_exp = big_exp - $signed({8'd0, lsh});
    end

    rnd_up = norm[2] & (norm[3] | norm[1] | norm[0]);
    rsig   = {1'b0, norm[26:3]} + {24'd0, rnd_up};
    r_exp  = rsig[24] ? n_exp + 13'sd1 : n_exp;
    r_frac = rsig[24] ? rsig[23:1] : rsig[22:0];

    if (sum == 28'd0)             gen = 32'd0;
    else if (r_exp > 13'sd127)    gen = {big_sgn, 8'hFF, 23'd0};
    else if (r_exp < -13'sd126)   gen = {big_sgn, 31'd0};
    else                          gen = {big_sgn, r_exp[7:0] + 8'd127, r_frac};

    if (ha.nan | hb.nan | a_nan | (p_inf & p_zero) | (p_inf & a_inf & (p_sgn != a_sgn)))
      nxt = QNAN;
    else if (p_inf)  nxt = {p_sgn, 8'hFF, 23'd0};
    else if (a_inf)  nxt = acc_out;
    else if (p_zero) nxt = a_zero ? {a_sgn & p_sgn, 31'd0} : acc_out;
    else             nxt = gen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out   <= 32'd0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid & ~clr;
      if (clr)           acc_out <= 32'd0;
      else if (in_valid) acc_out <= nxt;
    end
  end

endmodule

module half_mac_fp32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        in_valid,
  input logic [31:0] acc_out,
  input logic        out_valid
);

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_out == 32'd0) && !out_valid);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(acc_out) && !out_valid);

  // R6
  nan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out == 32'h7FC0_0000 && !clr) |=> (acc_out == 32'h7FC0_0000));

  // R6
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out[30:23] == 8'hFF && acc_out[22:0] != 23'd0) |-> (acc_out == 32'h7FC0_0000));

  // R4
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out[30:23] == 8'd0) |-> (acc_out[22:0] == 23'd0));

endmodule

bind half_mac_fp32 half_mac_fp32_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .acc_out(acc_out), .out_valid(out_valid)
);

// File: tb/half_mac_fp32_tb.sv
module half_mac_fp32_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        fmt_bf16 = 1'b0;
  logic [15:0] op_a = 16'd0;
  logic [15:0] op_b = 16'd0;
  logic [31:0] acc_out;
  logic        out_valid;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] model = 32'd0;

  always #5 clk = ~clk;

  half_mac_fp32 u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .fmt_bf16(fmt_bf16),
    .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .out_valid(out_valid)
  );

  function automatic void split(input logic [15:0] x, input bit bf, output bit z, output bit inf,
                                output bit nan, output bit s, output int e, output logic [127:0] m);
    int ef, ff, fb, bias, emax;
    fb   = bf ? 7 : 10;
    bias = bf ? 127 : 15;
    emax = bf ? 255 : 31;
    ef   = bf ? int'(x[14:7]) : int'(x[14:10]);
    ff   = bf ? int'(x[6:0]) : int'(x[9:0]);
    s    = x[15];
    z    = (ef == 0);
    inf  = (ef == emax) && (ff == 0);
    nan  = (ef == emax) && (ff != 0);
    m    = (128'd1 << fb) | 128'(ff);
    e    = ef - bias - fb;
  endfunction

  function automatic logic [31:0] rnd_pack(input bit sg, input logic [127:0] m, input int sc);
    int p, r, e;
    logic [127:0] keep, rem, half;
    p = 0;
    for (int i = 0; i < 128; i++) if (m[i]) p = i;
    r = p - 23;
    if (p > 23) begin
      keep = m >> r;
      rem  = m & ((128'd1 << r) - 128'd1);
      half = 128'd1 << (r - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 128'd1;
      if (keep[24]) begin
        keep = keep >> 1;
        r = r + 1;
      end
    end else begin
      keep = m << (23 - p);
    end
    e = sc + r + 23;
    if (e > 127) return {sg, 8'hFF, 23'd0};
    if (e < -126) return {sg, 31'd0};
    return {sg, 8'(e + 127), keep[22:0]};
  endfunction

  function automatic logic [31:0] ref_mac(input logic [31:0] acc, input logic [15:0] a,
                                          input logic [15:0] b, input bit bf);
    bit az, ai, an, as_, bz, bi, bn, bs, cz, ci, cn, cs, ps, pz, pin, hs, ls;
    int ae, be, ce, pe, he, le, d, sc;
    logic [127:0] am, bm, cm, pm, hm, lm;
    split(a, bf, az, ai, an, as_, ae, am);
    split(b, bf, bz, bi, bn, bs, be, bm);
    cs  = acc[31];
    cz  = (acc[30:23] == 8'd0);
    ci  = (acc[30:23] == 8'hFF) && (acc[22:0] == 23'd0);
    cn  = (acc[30:23] == 8'hFF) && (acc[22:0] != 23'd0);
    cm  = {104'd1, acc[22:0]};
    ce  = int'(acc[30:23]) - 150;
    ps  = as_ ^ bs;
    pz  = az | bz;
    pin = ai | bi;
    if (an || bn || cn || (pin && pz) || (pin && ci && ps != cs)) return 32'h7FC0_0000;
    if (pin) return {ps, 8'hFF, 23'd0};
    if (ci) return acc;
    if (pz) return cz ? {cs & ps, 31'd0} : acc;
    pm = am * bm;
    pe = ae + be;
    if (cz) return rnd_pack(ps, pm, pe);
    if (pe >= ce) begin hm = pm; he = pe; hs = ps; lm = cm; le = ce; ls = cs; end
    else          begin hm = cm; he = ce; hs = cs; lm = pm; le = pe; ls = ps; end
    d = he - le;
    if (d > 64) begin hm = hm << 40; lm = 128'd1; sc = he - 40; end
    else        begin hm = hm << d; sc = le; end
    if (hs == ls) return rnd_pack(hs, hm + lm, sc);
    if (hm > lm) return rnd_pack(hs, hm - lm, sc);
    if (lm > hm) return rnd_pack(ls, lm - hm, sc);
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input bit bf, input string req);
    @(negedge clk);
    op_a = a; op_b = b; fmt_bf16 = bf; in_valid = 1'b1;
    model = ref_mac(model, a, b, bf);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, acc_out, model);
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model = 32'd0;
    chk("R9 clear", acc_out, 32'd0);
    chk("R9 clear valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R11 acc", acc_out, 32'd0);
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_basic();
    do_clear();
    step(16'h3E00, 16'h4000, 1'b0, "R1 R3 fp16 1.5*2");
    chk("R1 fp16 value", acc_out, 32'h4040_0000);
    do_clear();
    step(16'h3FC0, 16'h3FC0, 1'b1, "R1 R3 bf16 1.5*1.5");
    chk("R1 bf16 value", acc_out, 32'h4010_0000);
    step(16'hC000, 16'h3F80, 1'b1, "R3 bf16 -2");
    chk("R3 bf16 sum", acc_out, 32'h3E80_0000);
  endtask

  task automatic t_subnormal_in();
    do_clear();
    step(16'h3E00, 16'h4000, 1'b0, "R2 setup");
    step(16'h0001, 16'h7BFF, 1'b0, "R2 fp16 subnormal");
    chk("R2 fp16 unchanged", acc_out, 32'h4040_0000);
    step(16'h0040, 16'h7F00, 1'b1, "R2 bf16 subnormal");
    chk("R2 bf16 unchanged", acc_out, 32'h4040_0000);
    step(16'h7C00, 16'h0001, 1'b0, "R2 R6 inf*subnormal");
    chk("R6 inf*flushed", acc_out, 32'h7FC0_0000);
  endtask

  task automatic t_lost_and_tie();
    do_clear();
    step(16'h3C00, 16'h3C00, 1'b0, "R3 one");
    for (int i = 0; i < 16; i++) step(16'h0400, 16'h0400, 1'b0, "R3 tiny product lost");
    chk("R3 lost stays 1.0", acc_out, 32'h3F80_0000);
    step(16'h0C00, 16'h0C00, 1'b0, "R3 tie even down");
    chk("R3 tie down", acc_out, 32'h3F80_0000);
    step(16'h0C00, 16'h1000, 1'b0, "R3 one ulp");
    chk("R3 ulp", acc_out, 32'h3F80_0001);
    step(16'h0C00, 16'h0C00, 1'b0, "R3 tie even up");
    chk("R3 tie up", acc_out, 32'h3F80_0002);
  endtask

  task automatic t_underflow();
    do_clear();
    step(16'h1F80, 16'h1F80, 1'b1, "R4 product flush");
    chk("R4 +flush", acc_out, 32'h0000_0000);
    step(16'h9F80, 16'h1F80, 1'b1, "R4 negative flush");
    chk("R4 -flush", acc_out, 32'h8000_0000);
    step(16'h8000, 16'h3C00, 1'b0, "R8 -0 + -0");
    chk("R8 same sign", acc_out, 32'h8000_0000);
    step(16'h0000, 16'h3C00, 1'b0, "R8 -0 + +0");
    chk("R8 mixed sign", acc_out, 32'h0000_0000);
    step(16'h0080, 16'h3F80, 1'b1, "R4 min normal");
    chk("R4 min normal", acc_out, 32'h0080_0000);
    step(16'h3F00, 16'h8080, 1'b1, "R4 sum flush");
    chk("R4 sum below min", acc_out, 32'h0000_0000);
  endtask

  task automatic t_overflow();
    do_clear();
    step(16'h7F00, 16'h4000, 1'b1, "R5 +overflow");
    chk("R5 +inf", acc_out, 32'h7F80_0000);
    do_clear();
    step(16'hFF00, 16'h4000, 1'b1, "R5 -overflow");
    chk("R5 -inf", acc_out, 32'hFF80_0000);
  endtask

  task automatic t_special();
    do_clear();
    step(16'h7C00, 16'h4000, 1'b0, "R7 inf product");
    chk("R7 +inf", acc_out, 32'h7F80_0000);
    step(16'h3C00, 16'hC000, 1'b0, "R7 inf + finite");
    chk("R7 inf kept", acc_out, 32'h7F80_0000);
    step(16'hFC00, 16'h3C00, 1'b0, "R6 inf - inf");
    chk("R6 opposite inf", acc_out, 32'h7FC0_0000);
    step(16'h3C00, 16'h3C00, 1'b0, "R6 nan kept");
    chk("R6 nan sticky", acc_out, 32'h7FC0_0000);
    do_clear();
    step(16'h7C00, 16'h0000, 1'b0, "R6 inf*0");
    chk("R6 inf*0", acc_out, 32'h7FC0_0000);
    do_clear();
    step(16'h7FC1, 16'h3F80, 1'b1, "R6 nan operand");
    chk("R6 nan in", acc_out, 32'h7FC0_0000);
  endtask

  task automatic t_cancel();
    do_clear();
    step(16'h3E00, 16'h4000, 1'b0, "R8 setup");
    step(16'hBE00, 16'h4000, 1'b0, "R8 cancel");
    chk("R8 +0", acc_out, 32'h0000_0000);
  endtask

  task automatic t_hold_and_priority();
    logic [31:0] held;
    do_clear();
    step(16'h4200, 16'h3C00, 1'b0, "R10 setup");
    held = acc_out;
    @(negedge clk);
    op_a = 16'h7C00; op_b = 16'h3C00; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle hold", acc_out, held);
    chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; op_a = 16'h3C00; op_b = 16'h3C00;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    model = 32'd0;
    chk("R9 clear beats valid", acc_out, 32'd0);
    chk("R9 dropped step valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) do_clear();
      step(16'($urandom), 16'($urandom), 1'($urandom), "R3 random");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_subnormal_in();
    t_lost_and_tie();
    t_underflow();
    t_overflow();
    t_special();
    t_cancel();
    t_hold_and_priority();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule